// File: doc/BRIEF.md
# Track-Phase Clock-Enable Hold Controller

This controller sits beside a free-running successive-approximation sequencer and stops it at the very end of its track phase. The sequencer runs on the shared clock only while `conv_clk_en` is high. Its start input is held active and its flag reset is held inactive, so it loops through a fixed frame. Each frame has `TRACK_LEN` track periods followed by the conversion periods. The sequencer raises `conv_ready` for the first track period of every frame.

The controller passes `conv_ready` through a short register chain. The chain advances only on enabled rising edges, so it marks the last track period. On the falling edge inside that period, the controller drops `conv_clk_en` and raises `armed`. The sequencer is then frozen while it is still tracking.

A high-to-low step on `capture_n`, seen on falling edges while `armed` is high, restores the enable. The next rising edge then ends the track phase and starts the hold. Because the enable only changes on falling edges, it never moves while the clock is high.

Top module: `track_hold_gate`

## Requirements
- R1: While `rst_n` is low, `conv_clk_en` is 1 and `armed` is 0.
- R2: After reset, `conv_clk_en` stays 1 until the hold point is first reached. The hold point is the falling edge in the enabled period that begins `TRACK_LEN-1` enabled rising edges after the edge on which `conv_ready` is first registered high.
- R3: At the hold point, `armed` rises to 1 and `conv_clk_en` falls to 0 on that same falling edge. The converter has then completed exactly `TRACK_LEN` periods of the current frame. `TRACK_LEN` is 3 by default and must be at least 2.
- R4: While `armed` is 1 and no capture is seen, `armed` stays 1 and `conv_clk_en` stays 0 for any length of time. The converter state is frozen during this time.
- R5: A capture is `capture_n` sampled 1 on one falling edge and 0 on the next. A capture seen while `armed` is 1 clears `armed` and sets `conv_clk_en` on that falling edge. The following rising edge moves the converter out of its last track period.
- R6: A capture seen while `armed` is 0 is ignored: `armed` stays 0 and `conv_clk_en` stays 1.
- R7: Holding `capture_n` low is a single capture at most. If `capture_n` is already low when the hold point arrives, `armed` still rises and stays 1 until a new high-to-low step on `capture_n`.
- R8: A release is followed by exactly one full converter frame of enabled rising edges before `armed` rises again. For the frame used here, that is 10 conversion periods plus 3 track periods, i.e. 13 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the converter; the enable changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_ready | input | 1 | Converter ready flag, high during the first track period of a frame |
| capture_n | input | 1 | Active-low capture command, acted on at a high-to-low step |
| conv_clk_en | output | 1 | Clock enable for the converter sequencer |
| armed | output | 1 | High while the converter is parked at the end of its track phase |

## Verification
The assertions assume that `conv_ready` comes from a sequencer that advances only on enabled rising edges. They also assume the flag lasts one period per frame, so the chain tap falls on the first enabled edge after a release. They further assume that `capture_n` is synchronous to `clk` and is stable across each falling edge. The stimulus meets these assumptions in two ways: a frame counter in the bench produces `conv_ready`, and every change to `capture_n` is made just after a rising edge.

// File: rtl/track_hold_gate.sv
module track_hold_gate #(
  parameter int TRACK_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_ready,
  input  logic capture_n,
  output logic conv_clk_en,
  output logic armed
);
  localparam int DEPTH = TRACK_LEN - 1;

  logic [DEPTH-1:0] chain;
  logic [DEPTH:0]   feed;
  logic             tap;
  logic             hold;
  logic             cap_q;
  logic             capture_seen;

  assign feed = {chain, conv_ready};
  assign tap  = chain[DEPTH-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           chain <= '0;
    else if (conv_clk_en) chain <= feed[DEPTH-1:0];

  assign capture_seen = cap_q && !capture_n;

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) begin
      hold  <= 1'b0;
      cap_q <= 1'b1;
    end else begin
      cap_q <= capture_n;
      if (hold) begin
        if (capture_seen) hold <= 1'b0;
      end else if (tap) begin
        hold <= 1'b1;
      end
    end

  assign armed       = hold;
  assign conv_clk_en = !hold;
endmodule

// File: rtl/track_hold_gate_chk.sv
module track_hold_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic capture_n,
  input logic armed,
  input logic tap
);
  p_set_r3: assert property (@(negedge clk) disable iff (!rst_n)
    (!armed && tap) |=> armed);

  p_idle_r6: assert property (@(negedge clk) disable iff (!rst_n)
    (!armed && !tap) |=> !armed);

  p_keep_r4: assert property (@(negedge clk) disable iff (!rst_n)
    (armed && !($past(capture_n) && !capture_n)) |=> armed);

  p_release_r5: assert property (@(negedge clk) disable iff (!rst_n)
    (armed && $past(capture_n) && !capture_n) |=> !armed);
endmodule

bind track_hold_gate track_hold_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .capture_n(capture_n), .armed(armed), .tap(tap)
);

// File: tb/sim_track_hold_gate.sv
module sim_track_hold_gate;
  localparam int TRACK = 3;
  localparam int CONV  = 10;
  localparam int FRAME = TRACK + CONV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic capture_n = 1'b1;
  logic conv_ready;
  logic en, armed;

  int total = 0, bad = 0;
  bit done = 1'b0;
  int period;
  int adv = 0;
  int base = 0;
  int exp_q[$];

  always #2 clk = ~clk;

  // converter model: frame counter 1..FRAME, ready in period 1
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) period <= FRAME;
    else if (en) period <= (period == FRAME) ? 1 : period + 1;
  assign conv_ready = (period == 1);

  always @(posedge clk) if (rst_n && en) adv <= adv + 1;

  track_hold_gate #(.TRACK_LEN(TRACK)) u0 (
    .clk(clk), .rst_n(rst_n), .conv_ready(conv_ready), .capture_n(capture_n),
    .conv_clk_en(en), .armed(armed)
  );

  task automatic check(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_armed();
    for (int i = 0; i < 100 && !armed; i++) tick();
  endtask

  // driver: issue one capture pulse on an armed converter, expect one frame
  task automatic release_capture();
    wait_armed();
    check("R4 armed before capture", armed, 1);
    capture_n = 1'b0;
    exp_q.push_back(FRAME);
    tick();
    check("R5 armed cleared", armed, 0);
    check("R5 enable restored", en, 1);
    check("R5 track ended on next edge", period, TRACK + 1);
    capture_n = 1'b1;
  endtask

  // monitor / scoreboard
  bit armed_prev = 1'b0;
  int frozen;
  always begin
    tick();
    if (rst_n && !done) begin
      if (armed && !armed_prev) begin
        if (exp_q.size() == 0) check("R8 unexpected hold", 1, 0);
        else check("R8 enabled edges to hold", adv - base, exp_q.pop_front());
        check("R3 period at hold", period, TRACK);
        check("R3 enable low at hold", en, 0);
        frozen = period;
      end else if (armed && armed_prev) begin
        check("R4 converter frozen", period, frozen);
      end else if (!armed && armed_prev) begin
        base = adv - 1;
      end
      armed_prev = armed;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    check("R1 enable in reset", en, 1);
    check("R1 armed in reset", armed, 0);
    exp_q.push_back(TRACK);
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    check("R2 enable after reset", en, 1);
    tick();
    check("R2 enable before hold point", en, 1);
    wait_armed();
    for (int i = 0; i < 20; i++) tick();
    check("R4 still armed after long wait", armed, 1);
    check("R4 enable still low", en, 0);
    release_capture();

    // R6: pulses while not armed
    for (int i = 0; i < 4; i++) tick();
    capture_n = 1'b0; tick(); capture_n = 1'b1; tick();
    check("R6 armed after ignored capture", armed, 0);
    check("R6 enable after ignored capture", en, 1);
    capture_n = 1'b0; tick(); capture_n = 1'b1; tick();
    check("R6 second ignored capture", en, 1);
    release_capture();

    // R7: capture held low across the hold point
    tick();
    capture_n = 1'b0;
    wait_armed();
    check("R7 armed despite low capture", armed, 1);
    for (int i = 0; i < 6; i++) tick();
    check("R7 held low does not release", armed, 1);
    capture_n = 1'b1;
    tick();
    check("R7 rising capture does not release", armed, 1);
    release_capture();

    // immediate capture at the hold point, twice
    release_capture();
    release_capture();
    wait_armed();
    tick();
    check("R8 all holds seen", exp_q.size(), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule